// File: doc/BRIEF.md
# Pixel-to-Serial 28:4 Lane Serializer

The block turns one 28-bit parallel video word per pixel clock into four serial data lanes and one forwarded clock lane. The word holds 24 colour bits (red, green and blue, eight bits each), a horizontal sync, a vertical sync, a data-enable flag and a spare bit. Each lane sends seven bits per pixel period. A second clock, running at seven times the pixel rate and phase-aligned to it, drives the serial side. Electrical signalling, generation of the fast clock and the receiving side are not part of the block.

The capture edge of the pixel clock can be chosen. There are two packings for 24-bit colour. A reduced mode uses three lanes and holds the fourth lane low. An active-low shutdown input stops all serial activity and clears every register. After shutdown is released, the lanes stay low until the first newly captured word can go out whole, starting at a word boundary.

Top module: `pixelLaneSerializer`

## Requirements
- R1: Every pixel period, each lane sends exactly seven bits, transmit bit 0 first, one per bit-clock cycle. The clock lane sends 1,1,0,0,0,1,1 in the same cycle slots, so its first bit lines up with bit 0 of every data lane.
- R2: Bit positions use a 28-bit word D, and transmit order is fixed. Lane 0 sends D0,D1,D2,D3,D4,D6,D7. Lane 1 sends D8,D9,D12,D13,D14,D15,D18. Lane 2 sends D19,D20,D21,D22,D24,D25,D26. Lane 3 sends D27,D5,D10,D11,D16,D17,D23. D24 is hsync, D25 is vsync, D26 is dataEn and D23 is spare.
- R3: With fmtSel=0, colour bits 0..5 fill lanes 0-2. Red 0..5 go to D0..D4,D6. Green 0..5 go to D7,D8,D9,D12,D13,D14. Blue 0..5 go to D15,D18..D22. Lane 3 then carries R6,R7,G6,G7,B6,B7, then spare.
- R4: With fmtSel=1, colour bits 2..7 take the positions that bits 0..5 use in R3. Lane 3 then carries R0,R1,G0,G1,B0,B1, then spare.
- R5: With threeLane=1, lane 3 (dataLanes[3]) stays low at all times. Lanes 0-2 are unchanged.
- R6: With edgeSel=1, the pixel inputs are captured on the rising pixClk edge. With edgeSel=0, they are captured on the falling edge.
- R7: While shutdownN is low, all data lanes and the clock lane are low and every register is cleared.
- R8: After shutdownN rises, all lanes stay low for seven bit-clock cycles. The first word sent is the first one captured after the release, and it starts at a word boundary. No partial word is ever sent.
- R9: A word captured in a pixel period is loaded at the next bit-clock edge where the 0..6 bit counter reads 0. Its bit 0 appears on the lanes for the bit-clock cycle that follows that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bitClk | input | 1 | Serial clock, seven times the pixel rate, phase-aligned |
| pixClk | input | 1 | Pixel clock for the parallel inputs |
| shutdownN | input | 1 | Active-low shutdown and clear |
| edgeSel | input | 1 | 1 = capture on rising pixClk, 0 = capture on falling pixClk |
| fmtSel | input | 1 | 24-bit packing: 0 = low six bits on lanes 0-2, 1 = high six bits on lanes 0-2 |
| threeLane | input | 1 | 1 = three-lane mode, lane 3 held low |
| red | input | 8 | Red colour bits |
| green | input | 8 | Green colour bits |
| blue | input | 8 | Blue colour bits |
| hsync | input | 1 | Horizontal sync |
| vsync | input | 1 | Vertical sync |
| dataEn | input | 1 | Data enable |
| spare | input | 1 | Reserved bit carried on D23 |
| dataLanes | output | 4 | Serial data lanes, bit n is lane n |
| clkLane | output | 1 | Forwarded clock lane |

## Verification
Capture and load can meet in the same pixel period. The bench changes the pixel inputs twice in each period: once before the rising pixClk edge and once between the rising and falling edges. Only the word for the selected edge may arrive, which exercises the edge choice against the load at counter zero. The second pair of functions that meet is shutdown and the shift-out. Every run is cut off in the middle of a word, and the lanes must drop low at once. The next release must then show seven low cycles followed by a whole first word, decoded by a bench deserializer that rebuilds every lane word.

// File: rtl/pixlane_pkg.sv
package pixlane_pkg;
  localparam int COLOR_W = 8;

  typedef struct packed {
    logic                spare;
    logic                dataEn;
    logic                vsync;
    logic                hsync;
    logic [COLOR_W-1:0]  blue;
    logic [COLOR_W-1:0]  green;
    logic [COLOR_W-1:0]  red;
  } pixWord_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;  // transfer captured word into the shifters
    logic run;   // first whole word has been launched
  } serStb_t;
endpackage

// File: rtl/serLoadCtrl.sv
module serLoadCtrl
  import pixlane_pkg::*;
#(
  parameter int RATIO = 7
) (
  input  logic    bitClk,
  input  logic    shutdownN,
  input  logic    capValid,
  output serStb_t stb
);
  localparam int CW = $clog2(RATIO);
  localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

  logic [CW-1:0] bitCnt;
  logic          runQ;
  logic          loadNow;

  assign loadNow = (bitCnt == '0) && capValid;

  always_ff @(posedge bitClk or negedge shutdownN) begin
    if (!shutdownN) begin
      bitCnt <= '0;
      runQ   <= 1'b0;
    end else begin
      bitCnt <= (bitCnt == LAST) ? '0 : bitCnt + 1'b1;
      if (loadNow) runQ <= 1'b1;
    end
  end

  always_comb begin
    stb.load = loadNow;
    stb.run  = runQ;
  end
endmodule

// File: rtl/serLaneDatapath.sv
module serLaneDatapath
  import pixlane_pkg::*;
#(
  parameter int RATIO = 7,
  parameter int LANES = 4
) (
  input  logic             bitClk,
  input  logic             pixClk,
  input  logic             shutdownN,
  input  logic             edgeSel,
  input  logic             fmtSel,
  input  logic             threeLane,
  input  pixWord_t         pixIn,
  input  serStb_t          stb,
  output logic             capValid,
  output logic [LANES-1:0] dataLanes,
  output logic             clkLane
);
  localparam int WORD_W = RATIO * LANES;
  // transmit order of D-bit indices, lane by lane
  localparam int LANE_MAP [WORD_W] = '{
    0, 1, 2, 3, 4, 6, 7,
    8, 9, 12, 13, 14, 15, 18,
    19, 20, 21, 22, 24, 25, 26,
    27, 5, 10, 11, 16, 17, 23};

  function automatic logic [RATIO-1:0] clkPattern();
    logic [RATIO-1:0] p;
    for (int i = 0; i < RATIO; i++) p[i] = (i < 2) || (i >= RATIO - 2);
    return p;
  endfunction
  localparam logic [RATIO-1:0] CLK_PAT = clkPattern();

  // capture banks for both pixel-clock edges
  pixWord_t riseWord, fallWord, selWord;
  logic     riseValid, fallValid;

  always_ff @(posedge pixClk or negedge shutdownN) begin
    if (!shutdownN) begin
      riseWord  <= '0;
      riseValid <= 1'b0;
    end else begin
      riseWord  <= pixIn;
      riseValid <= 1'b1;
    end
  end

  always_ff @(negedge pixClk or negedge shutdownN) begin
    if (!shutdownN) begin
      fallWord  <= '0;
      fallValid <= 1'b0;
    end else begin
      fallWord  <= pixIn;
      fallValid <= 1'b1;
    end
  end

  assign selWord  = edgeSel ? riseWord : fallWord;
  assign capValid = edgeSel ? riseValid : fallValid;

  // colour packing into the D-bit word
  logic [5:0]        rLo, gLo, bLo;
  logic [1:0]        rHi, gHi, bHi;
  logic [WORD_W-1:0] dVec;

  always_comb begin
    rLo = fmtSel ? selWord.red[7:2]   : selWord.red[5:0];
    gLo = fmtSel ? selWord.green[7:2] : selWord.green[5:0];
    bLo = fmtSel ? selWord.blue[7:2]  : selWord.blue[5:0];
    rHi = fmtSel ? selWord.red[1:0]   : selWord.red[7:6];
    gHi = fmtSel ? selWord.green[1:0] : selWord.green[7:6];
    bHi = fmtSel ? selWord.blue[1:0]  : selWord.blue[7:6];
    dVec = '0;
    {dVec[6], dVec[4:0]}    = rLo;
    {dVec[14:12], dVec[9:7]} = gLo;
    {dVec[22:18], dVec[15]}  = bLo;
    dVec[26:24]             = {selWord.dataEn, selWord.vsync, selWord.hsync};
    {dVec[5], dVec[27]}     = rHi;
    dVec[11:10]             = gHi;
    dVec[17:16]             = bHi;
    dVec[23]                = selWord.spare;
  end

  // per-lane gather and shift-out
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [RATIO-1:0] laneWord;
    logic [RATIO-1:0] shiftQ;
    logic             laneOn;

    for (genvar b = 0; b < RATIO; b++) begin : g_bit
      assign laneWord[b] = dVec[LANE_MAP[l*RATIO + b]];
    end

    assign laneOn = !(threeLane && (l == LANES - 1));

    always_ff @(posedge bitClk or negedge shutdownN) begin
      if (!shutdownN)    shiftQ <= '0;
      else if (stb.load) shiftQ <= laneOn ? laneWord : '0;
      else               shiftQ <= shiftQ >> 1;
    end

    assign dataLanes[l] = shiftQ[0] & stb.run;
  end

  logic [RATIO-1:0] clkShift;
  always_ff @(posedge bitClk or negedge shutdownN) begin
    if (!shutdownN)    clkShift <= '0;
    else if (stb.load) clkShift <= CLK_PAT;
    else               clkShift <= clkShift >> 1;
  end
  assign clkLane = clkShift[0] & stb.run;
endmodule

// File: rtl/pixelLaneSerializer.sv
module pixelLaneSerializer
  import pixlane_pkg::*;
#(
  parameter int RATIO = 7,
  parameter int LANES = 4
) (
  input  logic             bitClk,
  input  logic             pixClk,
  input  logic             shutdownN,
  input  logic             edgeSel,
  input  logic             fmtSel,
  input  logic             threeLane,
  input  logic [7:0]       red,
  input  logic [7:0]       green,
  input  logic [7:0]       blue,
  input  logic             hsync,
  input  logic             vsync,
  input  logic             dataEn,
  input  logic             spare,
  output logic [LANES-1:0] dataLanes,
  output logic             clkLane
);
  pixWord_t pixIn;
  serStb_t  ctlStb;
  logic     capValid;

  always_comb begin
    pixIn.red    = red;
    pixIn.green  = green;
    pixIn.blue   = blue;
    pixIn.hsync  = hsync;
    pixIn.vsync  = vsync;
    pixIn.dataEn = dataEn;
    pixIn.spare  = spare;
  end

  serLoadCtrl #(.RATIO(RATIO)) u_ctrl (
    .bitClk   (bitClk),
    .shutdownN(shutdownN),
    .capValid (capValid),
    .stb      (ctlStb)
  );

  serLaneDatapath #(.RATIO(RATIO), .LANES(LANES)) u_dp (
    .bitClk   (bitClk),
    .pixClk   (pixClk),
    .shutdownN(shutdownN),
    .edgeSel  (edgeSel),
    .fmtSel   (fmtSel),
    .threeLane(threeLane),
    .pixIn    (pixIn),
    .stb      (ctlStb),
    .capValid (capValid),
    .dataLanes(dataLanes),
    .clkLane  (clkLane)
  );
endmodule

// File: rtl/laneSerChecker.sv
module laneSerChecker #(
  parameter int LANES = 4
) (
  input logic             bitClk,
  input logic             shutdownN,
  input logic             threeLane,
  input logic [LANES-1:0] dataLanes,
  input logic             clkLane,
  input logic             loadStb,
  input logic             running
);
  AST_SHDN_QUIET: assert property (@(posedge bitClk)
    !shutdownN |-> (dataLanes == '0 && !clkLane)); // R7

  AST_LANE3_IDLE: assert property (@(posedge bitClk) disable iff (!shutdownN)
    threeLane |-> !dataLanes[LANES-1]); // R5

  AST_SILENT_BEFORE_RUN: assert property (@(posedge bitClk) disable iff (!shutdownN)
    !running |-> (dataLanes == '0 && !clkLane)); // R8

  AST_CLK_FIRST_HIGH: assert property (@(posedge bitClk) disable iff (!shutdownN)
    loadStb |=> clkLane); // R1

  AST_CLK_MID_LOW: assert property (@(posedge bitClk) disable iff (!shutdownN)
    $past(loadStb, 3) |-> !clkLane); // R1

  AST_LOAD_SPACING: assert property (@(posedge bitClk) disable iff (!shutdownN)
    loadStb |=> !loadStb); // R9
endmodule

bind pixelLaneSerializer laneSerChecker #(.LANES(LANES)) u_chk (
  .bitClk   (bitClk),
  .shutdownN(shutdownN),
  .threeLane(threeLane),
  .dataLanes(dataLanes),
  .clkLane  (clkLane),
  .loadStb  (ctlStb.load),
  .running  (ctlStb.run)
);

// File: tb/sim_pixelLaneSerializer.sv
module sim_pixelLaneSerializer;
  localparam int CLK_PERIOD = 10;
  localparam int MAXP = 48;

  logic bitClk = 1'b0, pixClk = 1'b0, shutdownN = 1'b0;
  logic edgeSel = 1'b1, fmtSel = 1'b0, threeLane = 1'b0;
  logic [27:0] pixIn = '0;
  logic [3:0]  dataLanes;
  logic        clkLane;

  int nChecks = 0, nFails = 0, cyc = 0, eCnt = 0, nPix = 0;
  bit active = 1'b0, done = 1'b0;
  logic [27:0] wordA [MAXP];
  logic [27:0] wordB [MAXP];
  logic [6:0]  rxL [4];
  logic [6:0]  rxC;

  pixelLaneSerializer u0 (
    .bitClk(bitClk), .pixClk(pixClk), .shutdownN(shutdownN),
    .edgeSel(edgeSel), .fmtSel(fmtSel), .threeLane(threeLane),
    .red(pixIn[7:0]), .green(pixIn[15:8]), .blue(pixIn[23:16]),
    .hsync(pixIn[24]), .vsync(pixIn[25]), .dataEn(pixIn[26]), .spare(pixIn[27]),
    .dataLanes(dataLanes), .clkLane(clkLane));

  always #(CLK_PERIOD/2) bitClk = ~bitClk;

  // expected lanes {l3,l2,l1,l0}, each bit 0 sent first
  function automatic logic [27:0] expLanes(logic [27:0] px, bit fmt, bit three);
    logic [7:0] r, g, b;
    logic [5:0] rl, gl, bl;
    logic [1:0] rh, gh, bh;
    logic [6:0] l0, l1, l2, l3;
    r = px[7:0]; g = px[15:8]; b = px[23:16];
    rl = fmt ? r[7:2] : r[5:0]; rh = fmt ? r[1:0] : r[7:6];
    gl = fmt ? g[7:2] : g[5:0]; gh = fmt ? g[1:0] : g[7:6];
    bl = fmt ? b[7:2] : b[5:0]; bh = fmt ? b[1:0] : b[7:6];
    l0 = {gl[0], rl};
    l1 = {bl[1], bl[0], gl[5:1]};
    l2 = {px[26], px[25], px[24], bl[5:2]};
    l3 = three ? 7'd0 : {px[27], bh, gh, rh};
    return {l3, l2, l1, l0};
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // pixel clock and stimulus, locked to bit-clock edges since release
  always @(posedge bitClk) begin
    if (!shutdownN || !active) begin
      eCnt   <= 0;
      pixClk <= 1'b0;
    end else begin
      pixClk <= ((eCnt % 7) >= 2) && ((eCnt % 7) <= 4);
      if ((eCnt % 7) == 0 && (eCnt / 7) < MAXP) pixIn <= wordA[eCnt / 7];
      if ((eCnt % 7) == 3 && (eCnt / 7) < MAXP) pixIn <= wordB[eCnt / 7];
      eCnt <= eCnt + 1;
    end
  end

  // deserializer and checks
  always @(negedge bitClk) begin
    if (active && shutdownN) begin
      if (eCnt >= 1 && eCnt < 8) begin
        check(dataLanes == 4'd0 && !clkLane, "R8", "lanes before first word",
              {27'd0, clkLane, dataLanes}, 32'd0);
      end else if (eCnt >= 8) begin
        automatic int j = (eCnt - 8) % 7;
        automatic int p = (eCnt - 8) / 7;
        for (int l = 0; l < 4; l++) rxL[l][j] = dataLanes[l];
        rxC[j] = clkLane;
        if (j == 6 && p < nPix) begin
          automatic logic [27:0] src = edgeSel ? wordA[p] : wordB[p];
          automatic logic [27:0] ex  = expLanes(src, fmtSel, threeLane);
          automatic logic [27:0] got = {rxL[3], rxL[2], rxL[1], rxL[0]};
          check(rxC == 7'b1100011, "R1", "clock lane word", {25'd0, rxC}, 32'h63);
          check(got[20:0] == ex[20:0], fmtSel ? "R4/R2/R6/R9" : "R3/R2/R6/R9",
                "lanes0-2 word", {11'd0, got[20:0]}, {11'd0, ex[20:0]});
          check(got[27:21] == ex[27:21], threeLane ? "R5" : (fmtSel ? "R4" : "R3"),
                "lane3 word", {25'd0, got[27:21]}, {25'd0, ex[27:21]});
        end
      end
    end
  end

  task automatic enterShutdown();
    @(negedge bitClk); #1;
    shutdownN = 1'b0; active = 1'b0;
    #1;
    check(dataLanes == 4'd0 && !clkLane, "R7", "lanes in shutdown",
          {27'd0, clkLane, dataLanes}, 32'd0);
  endtask

  task automatic runCfg(bit f, bit e, bit t, int np);
    fmtSel = f; edgeSel = e; threeLane = t; nPix = np;
    wordA[0] = 28'hFFFFFFF; wordB[0] = 28'h0000000;
    wordA[1] = 28'h0000000; wordB[1] = 28'hFFFFFFF;
    wordA[2] = 28'hAAAAAAA; wordB[2] = 28'h5555555;
    for (int i = 3; i < MAXP; i++) begin
      wordA[i] = 28'($urandom);
      wordB[i] = 28'($urandom);
    end
    repeat (3) @(negedge bitClk);
    #1;
    shutdownN = 1'b1; active = 1'b1;
    while (eCnt < 8 + 7 * np + 3) @(negedge bitClk);
    enterShutdown(); // cut off mid-word
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge bitClk);
    check(dataLanes == 4'd0 && !clkLane, "R7", "reset state",
          {27'd0, clkLane, dataLanes}, 32'd0);
    runCfg(1'b0, 1'b1, 1'b0, 40);  // format 1, rising edge
    runCfg(1'b1, 1'b0, 1'b0, 40);  // format 2, falling edge
    runCfg(1'b0, 1'b0, 1'b1, 30);  // format 1, falling, three lanes
    runCfg(1'b1, 1'b1, 1'b1, 30);  // format 2, rising, three lanes
    runCfg(1'b1, 1'b1, 1'b0, 5);   // short run restarting after abort
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  always @(posedge bitClk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      nChecks++; nFails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule